// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block collects a vector of interrupt inputs and turns each new, enabled event into a posted memory write. It does not drive an interrupt line to a processor. It keeps four pieces of state: a sticky request vector, a pending vector that empties when software touches it, a mask, and a control word. A fifth register holds the message target. The write address is the target with its five low bits cleared. The write data is those five low bits, zero-extended. Setting bit 0 of the control word turns off message delivery, but the event registers keep updating.

Software reaches the registers through a command/response pair, each half with its own valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. One cycle later its response appears, and it stays on `rsp_*` until `rsp_ready` is seen high. `cmd_ready` goes low while an unaccepted response is still held. Messages leave on a single-beat write master. When `msg_valid` is high and `msg_ready` is low, `msg_addr` and `msg_data` hold steady. Only one write is ever in flight. Several inputs that rise in the same cycle wait in a per-input queue and are sent lowest input first.

Top module: `msi_irq_ctrl`

## Requirements
- R1: A rising edge on input k sets pending bit k on the next clock edge, whatever the mask holds.
- R2: A rising edge on input k while mask bit k is set sets request bit k. Request bits clear only on reset, and writes to the request register (offset 0) change nothing.
- R3: An unmasked rising edge while control bit 0 is clear produces exactly one message. Its address is target & 0xFFFFFFE0 and its data is target & 0x1F.
- R4: While control bit 0 is set, unmasked rising edges still set request bits but produce no message.
- R5: A read of the pending register (offset 2) returns its value and clears it. Any write to offset 2 clears it, whatever the data. An edge that arrives in the same cycle as the clear is kept.
- R6: A read of the control register (offset 3) returns bit 0 of the last value written, and every other bit reads as zero.
- R7: After reset the target register (offset 4) reads 0xFFFB0003, and request, mask, pending and control read as zero.
- R8: A mask write (offset 1) is stored exactly as written. `mask_err` pulses in the response cycle when the data sets any bit at or above NUM_IRQ, unless the data is all ones.
- R9: Inputs that rise together produce one message each, issued one at a time. A message that is not accepted keeps `msg_valid`, `msg_addr` and `msg_data` unchanged.
- R10: A command to an offset above 4 returns read data 0 with `rsp_err` high. Offsets 0 to 4 return `rsp_err` low.
- R11: While a response is held with `rsp_ready` low, `cmd_ready` is low and the response data stays stable.
- R12: An input held high counts as one event. Later cycles at high level add no pending bit, no request bit and no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Interrupt inputs, rising-edge sensitive |
| cmd_valid | input | 1 | Register command valid |
| cmd_ready | output | 1 | Register command ready |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Register word offset |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unimplemented offset |
| mask_err | output | 1 | Mask write with unimplemented bits (R8) |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The hardest state to reach is a queue holding several messages while the master port stalls. Every waiting message carries the same address and data, so the count of accepted writes is the only evidence of delivery. The bench raises four inputs in one cycle with `msg_ready` held low and checks that the head message stays frozen. It then toggles `msg_ready` and counts exactly four accepted writes. A second hard case is an edge landing on the same clock edge as a pending-register read. The bench drives both in the same half-cycle, expects the read to return the old value, and expects the new bit to appear on the next read.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int ALIGN_W = 5;

  localparam logic [ADDR_W-1:0] OFF_REQ  = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_PEND = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_TGT  = 3'd4;

  localparam logic [DATA_W-1:0] TGT_RESET = 32'hFFFB_0003;
endpackage

// File: rtl/msi_edge_detect.sv
module msi_edge_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] rise
);
  logic [NUM_IRQ-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  assign rise = irq_in & ~prev_q;

  // R12: a level held high does not report an edge again
  p_no_repeat_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == $past(irq_in)) |-> (rise == '0));
endmodule

// File: rtl/msi_reg_file.sv
module msi_reg_file
  import msi_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               mask_err,
  input  logic [NUM_IRQ-1:0] rise,
  output logic [NUM_IRQ-1:0] req_q,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] mask_eff,
  output logic               suppress,
  output logic [DATA_W-1:0]  target_q
);
  localparam logic [DATA_W-1:0] IMPL_BITS = DATA_W'({NUM_IRQ{1'b1}});

  logic [DATA_W-1:0] mask_q, ctrl_q, rd_data;
  logic              rd_err, accept, wr, pend_clr;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign wr        = accept && cmd_write;
  assign pend_clr  = accept && (cmd_addr == OFF_PEND);
  assign mask_eff  = mask_q[NUM_IRQ-1:0];
  assign suppress  = ctrl_q[0];

  always_comb begin
    rd_data = '0;
    rd_err  = 1'b0;
    case (cmd_addr)
      OFF_REQ:  rd_data = DATA_W'(req_q);
      OFF_MASK: rd_data = mask_q;
      OFF_PEND: rd_data = DATA_W'(pend_q);
      OFF_CTRL: rd_data = {{(DATA_W-1){1'b0}}, ctrl_q[0]};
      OFF_TGT:  rd_data = target_q;
      default:  rd_err  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      mask_err  <= 1'b0;
      req_q     <= '0;
      pend_q    <= '0;
      mask_q    <= '0;
      ctrl_q    <= '0;
      target_q  <= TGT_RESET;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_data;
        rsp_err   <= rd_err;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      mask_err <= wr && (cmd_addr == OFF_MASK) &&
                  (|(cmd_wdata & ~IMPL_BITS)) && !(&cmd_wdata);
      req_q  <= req_q | (rise & mask_q[NUM_IRQ-1:0]);
      pend_q <= (pend_clr ? '0 : pend_q) | rise;
      if (wr && cmd_addr == OFF_MASK) mask_q   <= cmd_wdata;
      if (wr && cmd_addr == OFF_CTRL) ctrl_q   <= cmd_wdata;
      if (wr && cmd_addr == OFF_TGT)  target_q <= cmd_wdata;
    end
  end

  // R2: request bits are never lost outside reset
  p_req_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & $past(req_q)) == $past(req_q)));
  // R11: a held response stays put
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  // R10: an error response never carries data
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: rtl/msi_msg_issuer.sv
module msi_msg_issuer
  import msi_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] new_req,
  input  logic [DATA_W-1:0]  target,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [DATA_W-1:0]  msg_addr,
  output logic [DATA_W-1:0]  msg_data
);
  logic [NUM_IRQ-1:0] queue_q, grant;
  logic               can_load;

  // lowest waiting input wins
  assign grant    = queue_q & (~queue_q + NUM_IRQ'(1));
  assign can_load = !msg_valid || msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      queue_q   <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      queue_q <= (queue_q & ~(can_load ? grant : '0)) | new_req;
      if (can_load) begin
        msg_valid <= |queue_q;
        if (|queue_q) begin
          msg_addr <= {target[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
          msg_data <= DATA_W'(target[ALIGN_W-1:0]);
        end
      end
    end
  end

  // R9: a stalled message is held unchanged
  p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R3: message address is aligned and data fits the low field
  p_msg_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[ALIGN_W-1:0] == '0 && msg_data[DATA_W-1:ALIGN_W] == '0));
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [2:0]         cmd_addr,
  input  logic [31:0]        cmd_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               mask_err,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic [NUM_IRQ-1:0] rise, req_q, pend_q, mask_eff, new_req;
  logic               suppress;
  logic [DATA_W-1:0]  target_q;

  msi_edge_detect #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise));

  msi_reg_file #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mask_err(mask_err), .rise(rise),
    .req_q(req_q), .pend_q(pend_q), .mask_eff(mask_eff),
    .suppress(suppress), .target_q(target_q));

  assign new_req = rise & mask_eff & {NUM_IRQ{~suppress}};

  msi_msg_issuer #(.NUM_IRQ(NUM_IRQ)) u_issue (
    .clk(clk), .rst_n(rst_n), .new_req(new_req), .target(target_q),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  // R1: every edge lands in pending
  p_pend_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
  // R2: every unmasked edge lands in request
  p_req_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & mask_eff)) |=> ((req_q & $past(rise & mask_eff)) == $past(rise & mask_eff)));
endmodule

// File: tb/test_msi_irq_ctrl.sv
module test_msi_irq_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1, msg_ready = 1'b1;
  logic [2:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, rsp_err, mask_err, msg_valid;
  logic [31:0] rsp_rdata, msg_addr, msg_data;

  int n_chk = 0, n_err = 0, n_msg = 0;
  logic [31:0] last_addr = '0, last_data = '0;
  logic [31:0] rd;
  logic er, me;
  bit done = 0;

  always #2 clk = ~clk;

  msi_irq_ctrl #(.NUM_IRQ(N)) i_msi_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mask_err(mask_err),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      n_msg++;
      last_addr = msg_addr;
      last_data = msg_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; msg_ready = 1'b1; rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acc(input bit w, input logic [2:0] a, input logic [31:0] d,
                     output logic [31:0] r, output logic e, output logic m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    r = rsp_rdata; e = rsp_err; m = mask_err;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] tgt;
    do_reset();
    // R7 reset values
    acc(0, 3'd0, 0, rd, er, me); chk("R7 request", rd, 0);
    acc(0, 3'd1, 0, rd, er, me); chk("R7 mask", rd, 0);
    acc(0, 3'd2, 0, rd, er, me); chk("R7 pending", rd, 0);
    acc(0, 3'd3, 0, rd, er, me); chk("R7 control", rd, 0);
    acc(0, 3'd4, 0, rd, er, me); chk("R7 target", rd, 32'hFFFB_0003);
    chk("R7 msg_valid", {31'b0, msg_valid}, 0);

    // Sweep: every input x masked/unmasked x delivery on/off
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 2; s++) begin
          do_reset();
          tgt = 32'h2000_0000 | (i << 8) | ((i * 5 + m + 2 * s) & 31);
          acc(1, 3'd4, tgt, rd, er, me);
          acc(1, 3'd1, m ? (32'd1 << i) : (~(32'd1 << i) & 32'hFF), rd, er, me);
          acc(1, 3'd3, s, rd, er, me);
          n_msg = 0;
          @(negedge clk); irq_in[i] = 1'b1;
          repeat (5) @(negedge clk);   // held high: R12 single event
          irq_in[i] = 1'b0;
          acc(0, 3'd2, 0, rd, er, me); chk("R1 pending set", rd, 32'd1 << i);
          acc(0, 3'd2, 0, rd, er, me); chk("R5 pending cleared by read", rd, 0);
          acc(0, 3'd0, 0, rd, er, me); chk("R2/R4 request", rd, m ? (32'd1 << i) : 0);
          chk("R3/R4/R12 message count", n_msg, (m && !s) ? 1 : 0);
          if (m && !s) begin
            chk("R3 message address", last_addr, tgt & 32'hFFFF_FFE0);
            chk("R3 message data", last_data, tgt & 32'h1F);
          end
        end
      end
    end

    // R2 writes to request ignored; R5 write clear and same-cycle edge
    do_reset();
    acc(1, 3'd1, 32'hFF, rd, er, me);
    @(negedge clk); irq_in[0] = 1'b1;
    acc(1, 3'd0, 32'h0, rd, er, me);
    acc(0, 3'd0, 0, rd, er, me); chk("R2 request write ignored", rd, 1);
    acc(1, 3'd2, 32'hFFFF_FFFF, rd, er, me);
    acc(0, 3'd2, 0, rd, er, me); chk("R5 pending cleared by write", rd, 0);
    @(negedge clk); irq_in[0] = 1'b0;
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[1] = 1'b1;
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 3'd2;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R5 read returns old value", rsp_rdata, 32'h8);
    acc(0, 3'd2, 0, rd, er, me); chk("R5 same-cycle edge kept", rd, 32'h2);
    irq_in = '0;

    // R6 control read-back
    acc(1, 3'd3, 32'hFFFF_FFFE, rd, er, me);
    acc(0, 3'd3, 0, rd, er, me); chk("R6 control bit0 clear", rd, 0);
    acc(1, 3'd3, 32'hFFFF_FFFF, rd, er, me);
    acc(0, 3'd3, 0, rd, er, me); chk("R6 control bit0 only", rd, 1);
    acc(1, 3'd3, 0, rd, er, me);

    // R8 mask error flag
    acc(1, 3'd1, 32'h100, rd, er, me); chk("R8 mask_err high bit", me, 1);
    acc(0, 3'd1, 0, rd, er, me); chk("R8 mask stored as written", rd, 32'h100);
    chk("R8 mask_err one pulse", me, 0);
    acc(1, 3'd1, 32'hFFFF_FFFF, rd, er, me); chk("R8 all ones no error", me, 0);
    acc(1, 3'd1, 32'hFF, rd, er, me); chk("R8 implemented bits no error", me, 0);

    // R10 offset decode
    for (int a = 5; a < 8; a++) begin
      acc(0, a[2:0], 0, rd, er, me);
      chk("R10 unmapped data", rd, 0);
      chk("R10 unmapped error", er, 1);
    end
    acc(0, 3'd1, 0, rd, er, me); chk("R10 mapped no error", er, 0);

    // R9 simultaneous edges under back-pressure
    do_reset();
    acc(1, 3'd1, 32'hFF, rd, er, me);
    acc(1, 3'd4, 32'h4000_0047, rd, er, me);
    n_msg = 0;
    @(negedge clk); msg_ready = 1'b0; irq_in = 8'hB4;
    repeat (4) @(negedge clk);
    chk("R9 stalled valid", {31'b0, msg_valid}, 1);
    chk("R9 stalled address", msg_addr, 32'h4000_0040);
    chk("R9 stalled data", msg_data, 32'h7);
    chk("R9 nothing accepted", n_msg, 0);
    for (int k = 0; k < 16; k++) begin
      msg_ready = k[0];
      @(negedge clk);
    end
    msg_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 one message per edge", n_msg, 4);
    chk("R9 queue drained", {31'b0, msg_valid}, 0);
    irq_in = '0;

    // R11 response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 3'd4;
    @(negedge clk);
    cmd_addr = 3'd1;
    chk("R11 response valid", {31'b0, rsp_valid}, 1);
    chk("R11 command stalled", {31'b0, cmd_ready}, 0);
    @(negedge clk);
    chk("R11 response held", rsp_rdata, 32'h4000_0047);
    rsp_ready = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R11 next command taken", rsp_rdata, 32'hFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule